// File: doc/BRIEF.md
# Daisy-Chain Converter Serial Reader

This block is the host side of a serial link to one or more cascaded sampling converters that share a single data line. A start request launches a burst of data-clock pulses. The clock is made by dividing the system clock, and it stays low outside the burst. The serial input is sampled on the falling or the rising edge of the data clock, as the caller chooses. The block can also discard a leading synchronisation slot when the converters emit one.

The cascade sends each converter's 16-bit result MSB first, followed by one separator bit. The reader discards the separators and any leading synchronisation slot. It hands out each recovered word with a one-cycle valid strobe and the position of its converter in the chain; position 0 is the converter nearest the host. A one-cycle done pulse marks the end of the burst. The caller sets the chain length, the sync option and the sampling edge per burst. All three are captured when the start is accepted.

Top module: `adc_chain_reader`

## Requirements
- R1: After reset, `dclk`, `rd_active`, `word_valid` and `done` are all low.
- R2: A burst of chain length L produces exactly 17·L data-clock pulses. One more is added when `sync_en` is 1, and one more when `rise_sample` is 1.
- R3: Each high and each low phase of `dclk` lasts EFF_HALF system cycles. EFF_HALF is HALF_DIV raised, if needed, so that `dclk` never exceeds 28.5 MHz. At the default 125 MHz system clock it is 3. `dclk` stays low whenever `rd_active` is low.
- R4: With `rise_sample` = 0, `sdata` is sampled at every falling edge of `dclk`. Bits are assembled MSB first, 16 per word.
- R5: With `rise_sample` = 1, the first rising edge of the burst is not sampled. `sdata` is sampled at every later rising edge.
- R6: With `sync_en` = 1, the first sampled slot of the burst is discarded and is not part of any word.
- R7: After each 16 data bits, the next sampled slot is a separator and is discarded. `word_valid` is high for exactly one cycle per word, with `word_idx` counting 0, 1, … in arrival order and always below L.
- R8: `rd_active` is high from the cycle after an accepted start until the final falling edge, which lasts 2·EFF_HALF cycles per pulse. `done` is high for exactly one cycle at that final edge, after the last word's strobe.
- R9: A start raised while a burst runs is ignored. The running burst keeps the length and modes captured at its own start.
- R10: A start with `chain_len` = 0 is ignored: no pulses, no `rd_active` and no `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Burst request, sampled while idle |
| chain_len | input | LEN_W | Number of cascaded converters |
| sync_en | input | 1 | 1: discard a leading synchronisation slot |
| rise_sample | input | 1 | 1: sample on rising edges, 0: on falling edges |
| sdata | input | 1 | Serial data from the last converter in the chain |
| dclk | output | 1 | Data clock to the converters, low when idle |
| rd_active | output | 1 | Read command, high during a burst |
| word_out | output | 16 | Recovered converter word |
| word_idx | output | LEN_W | Chain position of `word_out` |
| word_valid | output | 1 | One-cycle strobe for `word_out` |
| done | output | 1 | One-cycle end-of-burst pulse |

## Verification
The assertions check several properties on every cycle: the clock stays low while no burst runs, each high phase has the divided length, the valid and done strobes last a single cycle, the word index stays below the captured chain length, and the captured settings stay fixed during a burst. Other behaviours show only in the bench scenarios, which model the converter chain and compare against it. These are the pulse count for each combination of sync and edge mode, the bit order, the removal of the synchronisation and separator slots, the order of the indices, and the rejection of a second start or a zero length.

// File: rtl/adc_chain_pkg.sv
package adc_chain_pkg;

    localparam int WORD_BITS = 16;
    localparam int SLOT_BITS = WORD_BITS + 1;

    typedef enum logic {
        RD_IDLE = 1'b0,
        RD_RUN  = 1'b1
    } rd_state_t;

    typedef struct packed {
        logic sync;
        logic rise;
    } rd_mode_t;

    // Smallest half period, in system cycles, that keeps the data clock
    // at or below max_hz.
    function automatic int min_half(input int sys_hz, input int max_hz);
        longint span;
        longint h;
        span = 2 * longint'(max_hz);
        h    = (longint'(sys_hz) + span - 1) / span;
        if (h < 1) h = 1;
        return int'(h);
    endfunction

endpackage

// File: rtl/adc_dclk_gen.sv
module adc_dclk_gen #(
    parameter int HALF = 3,
    parameter int PCW  = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           run,
    input  logic [PCW-1:0] total_pulses,
    output logic           dclk,
    output logic           rise_evt,
    output logic           fall_evt,
    output logic           last_fall,
    output logic [PCW-1:0] pulse_cnt
);

    localparam int DCW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam int HCW = $clog2(HALF + 2);

    logic [DCW-1:0] div_cnt;
    logic           phase_end;

    assign phase_end = run && (div_cnt == DCW'(HALF - 1));
    assign rise_evt  = phase_end && !dclk;
    assign fall_evt  = phase_end && dclk;
    assign last_fall = fall_evt && (pulse_cnt == total_pulses - PCW'(1));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            div_cnt   <= '0;
            dclk      <= 1'b0;
            pulse_cnt <= '0;
        end else if (phase_end) begin
            div_cnt <= '0;
            dclk    <= ~dclk;
            if (dclk) pulse_cnt <= pulse_cnt + PCW'(1);
        end else begin
            div_cnt <= div_cnt + DCW'(1);
        end
    end

    // Checker-side count of cycles spent high.
    logic [HCW-1:0] hi_len;
    always_ff @(posedge clk) begin
        if (rst || !dclk) hi_len <= '0;
        else              hi_len <= hi_len + HCW'(1);
    end

    // R3
    high_phase_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(dclk) |-> (hi_len == HCW'(HALF)));

endmodule

// File: rtl/adc_word_deser.sv
module adc_word_deser #(
    parameter int IDXW = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clear,
    input  logic            drop_first,
    input  logic            sample_evt,
    input  logic            sdin,
    output logic [15:0]     word_out,
    output logic [IDXW-1:0] word_idx,
    output logic            word_valid
);

    import adc_chain_pkg::*;

    logic                 sync_pend;
    logic [4:0]           bit_pos;
    logic [WORD_BITS-1:0] shreg;
    logic [IDXW-1:0]      idx;
    logic [WORD_BITS-1:0] next_sh;

    assign next_sh = {shreg[WORD_BITS-2:0], sdin};

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_pend  <= 1'b0;
            bit_pos    <= '0;
            shreg      <= '0;
            idx        <= '0;
            word_out   <= '0;
            word_idx   <= '0;
            word_valid <= 1'b0;
        end else if (clear) begin
            sync_pend  <= drop_first;
            bit_pos    <= '0;
            idx        <= '0;
            word_valid <= 1'b0;
        end else begin
            word_valid <= 1'b0;
            if (sample_evt) begin
                if (sync_pend) begin
                    sync_pend <= 1'b0;
                end else if (bit_pos == 5'(WORD_BITS)) begin
                    bit_pos <= '0;
                    idx     <= idx + IDXW'(1);
                end else begin
                    shreg   <= next_sh;
                    bit_pos <= bit_pos + 5'd1;
                    if (bit_pos == 5'(WORD_BITS - 1)) begin
                        word_out   <= next_sh;
                        word_idx   <= idx;
                        word_valid <= 1'b1;
                    end
                end
            end
        end
    end

    // R7
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        word_valid |=> !word_valid);

endmodule

// File: rtl/adc_chain_reader.sv
module adc_chain_reader #(
    parameter int SYS_HZ      = 125_000_000,
    parameter int MAX_DCLK_HZ = 28_500_000,
    parameter int HALF_DIV    = 3,
    parameter int LEN_W       = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [LEN_W-1:0] chain_len,
    input  logic             sync_en,
    input  logic             rise_sample,
    input  logic             sdata,
    output logic             dclk,
    output logic             rd_active,
    output logic [15:0]      word_out,
    output logic [LEN_W-1:0] word_idx,
    output logic             word_valid,
    output logic             done
);

    import adc_chain_pkg::*;

    localparam int MIN_HALF   = min_half(SYS_HZ, MAX_DCLK_HZ);
    localparam int EFF_HALF   = (HALF_DIV < MIN_HALF) ? MIN_HALF : HALF_DIV;
    localparam int MAX_LEN    = (1 << LEN_W) - 1;
    localparam int MAX_PULSES = SLOT_BITS * MAX_LEN + 2;
    localparam int PCW        = $clog2(MAX_PULSES + 1);

    rd_state_t        state;
    rd_mode_t         mode_q;
    logic [LEN_W-1:0] len_q;
    logic [PCW-1:0]   total_q;
    logic             start_acc;
    logic             run;
    logic             rise_evt, fall_evt, last_fall;
    logic [PCW-1:0]   pulse_cnt;
    logic             sample_evt;

    assign run       = (state == RD_RUN);
    assign rd_active = run;
    assign start_acc = !run && start && (chain_len != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= RD_IDLE;
            mode_q  <= '0;
            len_q   <= '0;
            total_q <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                RD_IDLE: begin
                    if (start_acc) begin
                        state       <= RD_RUN;
                        len_q       <= chain_len;
                        mode_q.sync <= sync_en;
                        mode_q.rise <= rise_sample;
                        total_q     <= PCW'(SLOT_BITS) * PCW'(chain_len)
                                     + PCW'(sync_en) + PCW'(rise_sample);
                    end
                end
                RD_RUN: begin
                    if (last_fall) begin
                        state <= RD_IDLE;
                        done  <= 1'b1;
                    end
                end
                default: state <= RD_IDLE;
            endcase
        end
    end

    adc_dclk_gen #(
        .HALF (EFF_HALF),
        .PCW  (PCW)
    ) u_dclk (
        .clk          (clk),
        .rst          (rst),
        .run          (run),
        .total_pulses (total_q),
        .dclk         (dclk),
        .rise_evt     (rise_evt),
        .fall_evt     (fall_evt),
        .last_fall    (last_fall),
        .pulse_cnt    (pulse_cnt)
    );

    // Rising-edge mode skips the first rise: the data is not valid before it.
    assign sample_evt = mode_q.rise ? (rise_evt && (pulse_cnt != '0)) : fall_evt;

    adc_word_deser #(
        .IDXW (LEN_W)
    ) u_deser (
        .clk        (clk),
        .rst        (rst),
        .clear      (start_acc),
        .drop_first (sync_en),
        .sample_evt (sample_evt),
        .sdin       (sdata),
        .word_out   (word_out),
        .word_idx   (word_idx),
        .word_valid (word_valid)
    );

    // R3
    dclk_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_active |-> !dclk);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7
    idx_range_chk: assert property (@(posedge clk) disable iff (rst)
        word_valid |-> (word_idx < len_q));

    // R9
    hold_cfg_chk: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run)) |-> ($stable(len_q) && $stable(mode_q)));

    // R10
    zero_len_chk: assert property (@(posedge clk) disable iff (rst)
        (!run && start && chain_len == '0) |=> !rd_active);

endmodule

// File: tb/adc_chain_reader_tb.sv
module adc_chain_reader_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [2:0]  chain_len = '0;
    logic        sync_en = 1'b0;
    logic        rise_sample = 1'b0;
    logic        sdata = 1'b1;
    logic        dclk, rd_active, word_valid, done;
    logic [15:0] word_out;
    logic [2:0]  word_idx;

    always #4 clk = ~clk;

    adc_chain_reader u_dut (
        .clk(clk), .rst(rst), .start(start), .chain_len(chain_len),
        .sync_en(sync_en), .rise_sample(rise_sample), .sdata(sdata),
        .dclk(dclk), .rd_active(rd_active), .word_out(word_out),
        .word_idx(word_idx), .word_valid(word_valid), .done(done)
    );

    localparam int HALF = 3;

    int n_chk = 0, n_fail = 0, cyc = 0;

    // Converter chain model
    logic [15:0] mwords [0:7];
    int mlen = 1, msync = 0, mslot = 0;

    function automatic logic slot_bit(input int s);
        int k, w, p;
        k = s;
        if (msync != 0) begin
            if (k == 0) return 1'b1;
            k = k - 1;
        end
        w = k / 17;
        p = k % 17;
        if (w >= mlen) return 1'b1;
        if (p == 16) return 1'b0;
        return mwords[w][15 - p];
    endfunction

    always @(posedge dclk) begin
        #1;
        sdata = slot_bit(mslot);
        mslot = mslot + 1;
    end

    // Output monitor
    logic [15:0] got_w [0:7];
    logic [2:0]  got_i [0:7];
    int nvalid = 0, done_cnt = 0, rd_cyc = 0, hi_cyc = 0, rise_cnt = 0;

    always @(posedge dclk) rise_cnt = rise_cnt + 1;

    always @(negedge clk) begin
        if (word_valid) begin
            if (nvalid < 8) begin
                got_w[nvalid] = word_out;
                got_i[nvalid] = word_idx;
            end
            nvalid = nvalid + 1;
        end
        if (done)      done_cnt = done_cnt + 1;
        if (rd_active) rd_cyc   = rd_cyc + 1;
        if (dclk)      hi_cyc   = hi_cyc + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc > 100000) begin
            n_fail = n_fail + 1;
            n_chk  = n_chk + 1;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic clear_mon();
        nvalid = 0; done_cnt = 0; rd_cyc = 0; hi_cyc = 0; rise_cnt = 0;
        mslot = 0; sdata = 1'b1;
    endtask

    task automatic launch(input int len, input int sy, input int ri, input int seed);
        for (int i = 0; i < 8; i++)
            mwords[i] = 16'(seed * 40503 + i * 16'h1357) ^ 16'h8001;
        mlen = len; msync = sy;
        clear_mon();
        @(negedge clk);
        chain_len = 3'(len); sync_en = sy[0]; rise_sample = ri[0]; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 3000 && done_cnt == 0; i++) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic verify(input int len, input int sy, input int ri);
        int np;
        np = 17 * len + sy + ri;
        chk(rise_cnt == np, "R2 pulse count", rise_cnt, np);
        chk(hi_cyc == np * HALF, "R3 high cycles", hi_cyc, np * HALF);
        chk(rd_cyc == np * 2 * HALF, "R8 rd_active cycles", rd_cyc, np * 2 * HALF);
        chk(done_cnt == 1, "R8 done pulses", done_cnt, 1);
        chk(nvalid == len, "R7 word count", nvalid, len);
        for (int i = 0; i < len && i < 8; i++) begin
            if (ri != 0)
                chk(got_w[i] == mwords[i], "R5 word", got_w[i], mwords[i]);
            else
                chk(got_w[i] == mwords[i], "R4 word", got_w[i], mwords[i]);
            if (sy != 0)
                chk(got_w[i] == mwords[i], "R6 word after sync", got_w[i], mwords[i]);
            chk(got_i[i] == 3'(i), "R7 index", got_i[i], i);
        end
        chk(!dclk && !rd_active, "R3 idle after burst", {dclk, rd_active}, 0);
    endtask

    task automatic t_reset();
        chk(!dclk && !rd_active && !word_valid && !done, "R1 reset outputs",
            {dclk, rd_active, word_valid, done}, 0);
    endtask

    task automatic t_burst(input int len, input int sy, input int ri, input int seed);
        launch(len, sy, ri, seed);
        wait_done();
        verify(len, sy, ri);
    endtask

    task automatic t_busy_ignore();
        launch(2, 0, 0, 91);
        repeat (40) @(negedge clk);
        chain_len = 3'd5; sync_en = 1'b1; rise_sample = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        chk(nvalid == 2, "R9 words after ignored start", nvalid, 2);
        chk(rise_cnt == 34, "R9 pulses after ignored start", rise_cnt, 34);
        chk(got_w[1] == mwords[1], "R9 data kept", got_w[1], mwords[1]);
        repeat (20) @(negedge clk);
        chk(done_cnt == 1 && !rd_active, "R9 no second burst", done_cnt, 1);
    endtask

    task automatic t_zero_len();
        clear_mon();
        @(negedge clk);
        chain_len = 3'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (50) @(negedge clk);
        chk(rise_cnt == 0, "R10 no pulses", rise_cnt, 0);
        chk(rd_cyc == 0 && done_cnt == 0, "R10 no activity", rd_cyc + done_cnt, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        repeat (2) @(negedge clk);
        t_reset();
        t_burst(1, 0, 0, 1);
        t_burst(1, 1, 0, 2);
        t_burst(1, 0, 1, 3);
        t_burst(1, 1, 1, 4);
        t_burst(3, 1, 0, 5);
        t_burst(7, 0, 1, 6);
        t_burst(2, 0, 0, 7);
        t_burst(4, 1, 1, 8);
        t_busy_ignore();
        t_zero_len();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule